// File: doc/BRIEF.md
# Periodic Compare-Match Timer

This block is an up-counter that generates a periodic event. A free-running divider turns the base clock into a count enable at 1/2^k of the clock rate, with k from 0 to 7. On each enable the counter steps by one. When an enable finds the counter equal to the compare register, that step is a match. A match sets a sticky compare flag. It can reload the counter from a load value, and it can replace the compare value with a preload value.

Because the compare value is double-buffered, software may present the next period length on the preload input at any time. The new value takes effect only at the next match. The running period is never cut short or stretched.

All pins are plain control and status levels or one-cycle strobes. There is no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `cmp_period_timer`

## Requirements
- R1: After reset the count output is 0, the compare flag and irq are 0, and the compare value holds the parameter CMP_RST (default all ones).
- R2: While run is 1, an internal divider enables one count step every 2^div_sel clock cycles. div_sel = 0 gives every cycle and div_sel = 7 gives every 128th cycle. The first step after run rises falls on the 2^div_sel-th rising edge.
- R3: While run is 0 the counter keeps its value, no match occurs and the divider restarts from zero.
- R4: A count step taken while the count equals the compare value is a match. The compare flag reads 1 from the edge of that step onward.
- R5: On a match with reload_en = 1 the counter takes load_val. On any other count step the counter adds one and wraps modulo 2^CNT_W.
- R6: On a match with pre_en = 1 the compare value takes pre_val. The compare value changes at no other time except on a cmp_wr strobe, so changes to pre_val between matches leave the running period untouched.
- R7: The compare flag stays set until flag_clr is 1 for a cycle. If a match falls in the same cycle as flag_clr, the flag stays set.
- R8: irq is 1 exactly when the compare flag is 1 and irq_en is 1.
- R9: cnt_load = 1 loads load_val into the counter at the next edge and suppresses any match in that cycle. cmp_wr = 1 writes cmp_wdata to the compare value and takes priority over a preload.
- R10: With reload_en = 1, a load value L and a compare value C ≥ L, matches recur every (C − L + 1)·2^div_sel clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counting enabled when 1 |
| div_sel | input | SEL_W | Divider exponent: step every 2^div_sel cycles |
| load_val | input | CNT_W | Value loaded on cnt_load or on a reloading match |
| cnt_load | input | 1 | Strobe: load counter from load_val |
| reload_en | input | 1 | Reload counter on match |
| cmp_wr | input | 1 | Strobe: write compare value directly |
| cmp_wdata | input | CNT_W | Data for cmp_wr |
| pre_en | input | 1 | Refresh compare value from pre_val on match |
| pre_val | input | CNT_W | Next-period compare value |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one clear of the compare flag |
| count | output | CNT_W | Current counter value |
| cmp_value | output | CNT_W | Active compare value |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
A divider phase error shows on the count output within 2^div_sel cycles, as a step on the wrong edge. A stale or early compare update shows on cmp_value at the first match after the preload changes. A wrong match comparison shows one step later: the count keeps rising past the compare value instead of reloading, and the flag fails to rise. A lost flag-clear race shows only in the single cycle where flag_clr meets a match, so the bench steers into that cycle on purpose as well as relying on random stimulus.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  // Source of the counter's next value
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_LOAD = 2'd2
  } cnt_src_e;
endpackage

// File: rtl/cpt_prescaler.sv
module cpt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // mask keeps the low div_sel bits of the divider
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (div_sel > SEL_W'(i));
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cpt_compare.sv
module cpt_compare #(
  parameter int                 CNT_W   = 16,
  parameter logic [CNT_W-1:0]   CMP_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             pre_en,
  input  logic [CNT_W-1:0] pre_val,
  output logic [CNT_W-1:0] cmp_value,
  output logic             match
);
  logic [CNT_W-1:0] cmp_q;

  assign match     = tick && !cnt_load && (count == cmp_q);
  assign cmp_value = cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cmp_q <= CMP_RST;
    else if (cmp_wr)          cmp_q <= cmp_wdata;
    else if (match && pre_en) cmp_q <= pre_val;
  end
endmodule

// File: rtl/cpt_flag.sv
module cpt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic flag_clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cpt_pkg::cnt_src_e  src,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else begin
      case (src)
        cpt_pkg::SRC_INC:  count <= count + 1'b1;
        cpt_pkg::SRC_LOAD: count <= load_val;
        default:           count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmp_period_timer.sv
module cmp_period_timer #(
  parameter int               CNT_W   = 16,
  parameter int               SEL_W   = 3,
  parameter logic [CNT_W-1:0] CMP_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_load,
  input  logic             reload_en,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             pre_en,
  input  logic [CNT_W-1:0] pre_val,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_value,
  output logic             cmp_flag,
  output logic             irq
);
  logic              tick;
  logic              match;
  cpt_pkg::cnt_src_e src;

  cpt_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
  );

  cpt_compare #(.CNT_W(CNT_W), .CMP_RST(CMP_RST)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(cnt_load),
    .count(count), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pre_en(pre_en), .pre_val(pre_val), .cmp_value(cmp_value), .match(match)
  );

  cpt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .match(match), .flag_clr(flag_clr), .flag(cmp_flag)
  );

  always_comb begin
    if (cnt_load)                src = cpt_pkg::SRC_LOAD;
    else if (match && reload_en) src = cpt_pkg::SRC_LOAD;
    else if (tick)               src = cpt_pkg::SRC_INC;
    else                         src = cpt_pkg::SRC_HOLD;
  end

  cpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .src(src), .load_val(load_val), .count(count)
  );

  assign irq = cmp_flag & irq_en;
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             cnt_load,
  input logic [CNT_W-1:0] load_val,
  input logic             cmp_wr,
  input logic             flag_clr,
  input logic             irq_en,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_value,
  input logic             cmp_flag,
  input logic             irq
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(count));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && count != cmp_value) |=> count == $past(count) + 1'b1);

  assert_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && count == cmp_value) |=> cmp_flag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !flag_clr) |=> cmp_flag);

  assert_cmp_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmp_wr) |=> $stable(cmp_value));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> count == $past(load_val));
endmodule

bind cmp_period_timer cpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt_load(cnt_load),
  .load_val(load_val), .cmp_wr(cmp_wr), .flag_clr(flag_clr), .irq_en(irq_en),
  .count(count), .cmp_value(cmp_value), .cmp_flag(cmp_flag), .irq(irq)
);

// File: tb/cmp_period_timer_tb.sv
module cmp_period_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [SEL_W-1:0] div_sel = '0;
  logic [CNT_W-1:0] load_val = '0;
  logic             cnt_load = 1'b0;
  logic             reload_en = 1'b0;
  logic             cmp_wr = 1'b0;
  logic [CNT_W-1:0] cmp_wdata = '0;
  logic             pre_en = 1'b0;
  logic [CNT_W-1:0] pre_val = '0;
  logic             irq_en = 1'b0;
  logic             flag_clr = 1'b0;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp_value;
  logic             cmp_flag;
  logic             irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_period_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .load_val(load_val),
    .cnt_load(cnt_load), .reload_en(reload_en), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .pre_en(pre_en), .pre_val(pre_val), .irq_en(irq_en), .flag_clr(flag_clr),
    .count(count), .cmp_value(cmp_value), .cmp_flag(cmp_flag), .irq(irq)
  );

  // Reference model built from the requirements
  logic [6:0]       m_div;
  logic [CNT_W-1:0] m_cnt;
  logic [CNT_W-1:0] m_cmp;
  logic             m_flag;

  function automatic logic model_tick(logic [6:0] d, logic [SEL_W-1:0] s, logic r);
    logic [6:0] mk;
    mk = 7'((8'd1 << s) - 8'd1);
    return r && ((d & mk) == mk);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = '0; m_cnt = '0; m_cmp = '1; m_flag = 1'b0;
    end else begin
      logic tk, mt;
      logic [CNT_W-1:0] nc, ncmp;
      tk = model_tick(m_div, div_sel, run);
      mt = tk && !cnt_load && (m_cnt == m_cmp);
      if (cnt_load)             nc = load_val;
      else if (mt && reload_en) nc = load_val;
      else if (tk)              nc = m_cnt + 1'b1;
      else                      nc = m_cnt;
      if (cmp_wr)               ncmp = cmp_wdata;
      else if (mt && pre_en)    ncmp = pre_val;
      else                      ncmp = m_cmp;
      if (mt)            m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      m_div = run ? m_div + 1'b1 : 7'd0;
      m_cnt = nc;
      m_cmp = ncmp;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R5", "count", int'(count), int'(m_cnt));
    check("R7", "cmp_flag", int'(cmp_flag), int'(m_flag));
    check("R8", "irq", int'(irq), int'(m_flag && irq_en));
    check("R6", "cmp_value", int'(cmp_value), int'(m_cmp));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int t_first, t_second, cyc_no;
    logic [CNT_W-1:0] prev;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "count", int'(count), 0);
    check("R1", "cmp_flag", int'(cmp_flag), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "cmp_value", int'(cmp_value), 16'hFFFF);
    rst_n = 1'b1;

    // R9: direct compare write and counter load
    cmp_wr = 1'b1; cmp_wdata = 16'd3; cnt_load = 1'b1; load_val = 16'd0;
    cyc(); cmp_wr = 1'b0; cnt_load = 1'b0;
    check("R9", "cmp after write", int'(cmp_value), 3);
    check("R9", "count after load", int'(count), 0);

    // R3: run low holds count
    repeat (5) cyc();
    check("R3", "count held", int'(count), 0);

    // R2: div_sel=2 steps every 4 cycles
    div_sel = 3'd2; run = 1'b1;
    repeat (3) cyc();
    check("R2", "count before 4th edge", int'(count), 0);
    cyc();
    check("R2", "count at 4th edge", int'(count), 1);

    // R4/R5: match with reload, div 1
    div_sel = 3'd0; reload_en = 1'b1; irq_en = 1'b1;
    while (!(count == cmp_value)) cyc();
    cyc();
    check("R4", "flag after match", int'(cmp_flag), 1);
    check("R5", "count reloaded", int'(count), 0);
    check("R8", "irq", int'(irq), 1);

    // R7: clear coincident with match keeps flag set
    while (!(count == cmp_value)) cyc();
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    check("R7", "flag kept on coincident clear", int'(cmp_flag), 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    check("R7", "flag cleared", int'(cmp_flag), 0);

    // R6: preload changes mid-period take effect only at match
    pre_en = 1'b1; pre_val = 16'd5;
    cyc();
    pre_val = 16'd7;
    if (count != cmp_value) check("R6", "cmp unchanged mid-period", int'(cmp_value), 3);
    while (!(count == cmp_value)) cyc();
    cyc();
    check("R6", "cmp took preload", int'(cmp_value), 7);
    pre_en = 1'b0;

    // R10: period with div 128, load 0, compare 9 -> 1280 cycles
    div_sel = 3'd7; cmp_wr = 1'b1; cmp_wdata = 16'd9; cnt_load = 1'b1; load_val = 16'd0;
    cyc(); cmp_wr = 1'b0; cnt_load = 1'b0;
    t_first = -1; t_second = -1; cyc_no = 0; prev = count;
    while (t_second < 0 && cyc_no < 5000) begin
      cyc(); cyc_no++;
      if (prev == 16'd9 && count == 16'd0) begin
        if (t_first < 0) t_first = cyc_no; else t_second = cyc_no;
      end
      prev = count;
    end
    check("R10", "match interval", t_second - t_first, 1280);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      run       = ($urandom % 8) != 0;
      div_sel   = SEL_W'(($urandom % 4 == 0) ? ($urandom % 8) : ($urandom % 2));
      cnt_load  = ($urandom % 40) == 0;
      load_val  = CNT_W'($urandom % 6);
      reload_en = ($urandom % 5) != 0;
      cmp_wr    = ($urandom % 60) == 0;
      cmp_wdata = CNT_W'(6 + $urandom % 10);
      pre_en    = ($urandom % 2) == 0;
      pre_val   = CNT_W'(6 + $urandom % 10);
      irq_en    = ($urandom % 3) != 0;
      flag_clr  = ($urandom % 6) == 0;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule